// File: doc/BRIEF.md
# Link Frame Receiver and Acknowledger

This block sits behind the 8b/10b decoder of a serial data link. It takes one 32-bit word per clock together with a four-bit mask that marks which bytes are control characters. It finds the start and end markers of each frame, checks the header, the payload length and a CRC-32, and writes the payload of each good data frame into one of a small set of receive blocks. For every frame it accepts, it raises a one-cycle acknowledge request carrying the frame's sequence number and link ID, so the transmit path can return an acknowledge frame. A frame that fails any check is dropped without a word. The sender then repeats it after its own timeout.

Receive blocks are selected by the low bits of the sequence number. Frames may therefore arrive out of order within a window as wide as the block count, and they are still handed to the consumer strictly in sequence order. The consumer side is a 64-bit stream with a valid/ready handshake and a last-word flag per block. Retransmitted copies of frames already held or already delivered are acknowledged again but never stored twice.

Top module: `link_frame_rx`

## Requirements
- R1: A word whose mask is 1111 (idle fill) is ignored in every state, including inside a frame, and never causes an acknowledge.
- R2: A frame is: start word 0x000000FB with mask 0001; sequence word (bit 31 must be 0); header word with link ID in bits 31:16 and payload length in bits 15:0, counted in 64-bit words and allowed from 1 to BLOCK_WORDS; two 32-bit words per payload entry, upper half first; the CRC word; end word 0x0000FD00 with mask 0010. All words other than the start, end and idle words have mask 0000.
- R3: The CRC is CRC-32 with polynomial 0x04C11DB7. It starts from all ones, takes each word most significant bit first, and applies no reflection and no final inversion. It covers the sequence, header and payload words. A frame whose CRC word differs is dropped with no acknowledge and no stored data.
- R4: For an accepted frame, ackValid is high for exactly one cycle, in the cycle after the end word is sampled. ackSeq then holds the sequence number with bit 31 set, and ackId holds the header's link ID.
- R5: A frame whose payload word count does not match its length field, whose length is 0 or above BLOCK_WORDS, or whose word after the CRC is not the end word, is dropped with no acknowledge.
- R6: A start word seen inside a frame abandons that frame without an acknowledge and begins a new one.
- R7: Blocks leave on outData in sequence order starting from 0. Each block is delivered as its payload entries in order, with outLast high on the final entry. While outValid is high and outReady is low, outValid, outData and outLast stay unchanged.
- R8: A frame whose sequence number is at most NUM_BLOCKS-1 ahead of the next sequence to deliver is stored and acknowledged whatever order it arrives in.
- R9: A good frame whose sequence number is already held, or is behind the next sequence to deliver (a 31-bit difference with bit 30 set), is acknowledged but not stored or delivered again.
- R10: A good frame NUM_BLOCKS or more ahead of the next sequence to deliver (no free block for it), or one with bit 31 of its sequence word set, is dropped with no acknowledge.
- R11: After reset, outValid and ackValid are low and the next sequence to deliver is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWord | input | 32 | Decoded word from the link |
| inK | input | 4 | Control-character flag per byte of inWord |
| ackValid | output | 1 | One-cycle acknowledge request |
| ackSeq | output | 32 | Acknowledged sequence number with bit 31 set |
| ackId | output | 16 | Link ID from the acknowledged frame |
| outValid | output | 1 | Consumer data available |
| outReady | input | 1 | Consumer accepts data |
| outData | output | 64 | Payload entry in sequence order |
| outLast | output | 1 | Final entry of the current block |

## Verification
The acknowledge request is due exactly one clock after the edge that samples the end word. The driver records that edge's cycle number next to each expected acknowledge, and the monitor compares the value and the cycle of every ackValid pulse it sees. Delivered data has no fixed latency, because it waits on earlier sequence numbers and on outReady, so the monitor compares order, content and the last flag on each handshake, sampled at the falling edge. Dropped frames are checked by letting the link sit idle for a fixed gap and then requiring that both expected queues are empty and that no extra acknowledge or data has arrived.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

  localparam logic [31:0] SOF_WORD = 32'h0000_00FB;
  localparam logic [3:0]  SOF_K    = 4'b0001;
  localparam logic [31:0] EOF_WORD = 32'h0000_FD00;
  localparam logic [3:0]  EOF_K    = 4'b0010;
  localparam logic [3:0]  IDLE_K   = 4'b1111;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    PS_IDLE, PS_SEQ, PS_HDR, PS_PAY, PS_CRC, PS_EOF
  } pstate_t;

  typedef enum logic [1:0] {
    ACT_DROP, ACT_STORE, ACT_REACK
  } act_t;

  // strobes from the parser to the block store
  typedef struct packed {
    logic wrEn;
    logic commit;
  } lfr_strobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/lfr_parser.sv
module lfr_parser
  import lfr_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_WORDS = 512,
  localparam int SLOT_W = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = $clog2(BLOCK_WORDS),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       inWord,
  input  logic [3:0]        inK,
  input  logic [30:0]       headSeq,
  input  logic [NUM_BLOCKS-1:0] slotBusy,
  output lfr_strobe_t       strb,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [63:0]       wrData,
  output logic [LEN_W-1:0]  commitLen,
  output logic              ackValid,
  output logic [31:0]       ackSeq,
  output logic [15:0]       ackId
);

  pstate_t     state;
  act_t        action, hdrAct;
  logic [31:0] crcReg;
  logic [31:0] seqReg;
  logic [15:0] idReg;
  logic [15:0] lenReg;
  logic [16:0] wordCnt;
  logic [16:0] lastCnt;
  logic [31:0] hiWord;
  logic        crcOk;
  logic        isIdle, isSof, isEof, isData;
  logic        lenOk;
  logic [30:0] seqDiff;
  logic [31:0] crcNext;
  logic        frameGood;

  assign isIdle  = (inK == IDLE_K);
  assign isSof   = (inK == SOF_K) && (inWord == SOF_WORD);
  assign isEof   = (inK == EOF_K) && (inWord == EOF_WORD);
  assign isData  = (inK == 4'b0000);
  assign crcNext = crcStep(crcReg, inWord);
  assign lastCnt = {lenReg, 1'b0} - 17'd1;
  assign seqDiff = seqReg[30:0] - headSeq;
  assign lenOk   = (inWord[15:0] != 16'd0) && (inWord[15:0] <= 16'(BLOCK_WORDS));

  // window decision taken when the header arrives
  always_comb begin
    if (seqReg[31])
      hdrAct = ACT_DROP;
    else if (seqDiff < 31'(NUM_BLOCKS))
      hdrAct = slotBusy[seqReg[SLOT_W-1:0]] ? ACT_REACK : ACT_STORE;
    else if (seqDiff[30])
      hdrAct = ACT_REACK;
    else
      hdrAct = ACT_DROP;
  end

  assign frameGood = (state == PS_EOF) && isEof && crcOk;

  assign strb.wrEn   = (state == PS_PAY) && isData && wordCnt[0] && (action == ACT_STORE);
  assign strb.commit = frameGood && (action == ACT_STORE);
  assign wrSlot      = seqReg[SLOT_W-1:0];
  assign wrAddr      = wordCnt[ADDR_W:1];
  assign wrData      = {hiWord, inWord};
  assign commitLen   = lenReg[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PS_IDLE;
      action  <= ACT_DROP;
      crcReg  <= CRC_INIT;
      seqReg  <= '0;
      idReg   <= '0;
      lenReg  <= '0;
      wordCnt <= '0;
      hiWord  <= '0;
      crcOk   <= 1'b0;
    end else if (isIdle) begin
      state <= state;
    end else if (isSof) begin
      state  <= PS_SEQ;
      crcReg <= CRC_INIT;
    end else begin
      unique case (state)
        PS_IDLE: state <= PS_IDLE;
        PS_SEQ: begin
          if (isData) begin
            seqReg <= inWord;
            crcReg <= crcNext;
            state  <= PS_HDR;
          end else state <= PS_IDLE;
        end
        PS_HDR: begin
          if (isData && lenOk && (hdrAct != ACT_DROP)) begin
            idReg   <= inWord[31:16];
            lenReg  <= inWord[15:0];
            action  <= hdrAct;
            crcReg  <= crcNext;
            wordCnt <= '0;
            state   <= PS_PAY;
          end else state <= PS_IDLE;
        end
        PS_PAY: begin
          if (isData) begin
            crcReg  <= crcNext;
            wordCnt <= wordCnt + 17'd1;
            if (!wordCnt[0]) hiWord <= inWord;
            if (wordCnt == lastCnt) state <= PS_CRC;
          end else state <= PS_IDLE;
        end
        PS_CRC: begin
          if (isData) begin
            crcOk <= (inWord == crcReg);
            state <= PS_EOF;
          end else state <= PS_IDLE;
        end
        PS_EOF: state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackSeq   <= '0;
      ackId    <= '0;
    end else begin
      ackValid <= frameGood && (action != ACT_DROP);
      if (frameGood) begin
        ackSeq <= {1'b1, seqReg[30:0]};
        ackId  <= idReg;
      end
    end
  end

endmodule

// File: rtl/lfr_blocks.sv
module lfr_blocks
  import lfr_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_WORDS = 512,
  localparam int SLOT_W = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = $clog2(BLOCK_WORDS),
  localparam int LEN_W  = ADDR_W + 1,
  localparam int MEM_W  = SLOT_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfr_strobe_t       strb,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [63:0]       wrData,
  input  logic [LEN_W-1:0]  commitLen,
  input  logic              outReady,
  output logic [30:0]       headSeq,
  output logic [NUM_BLOCKS-1:0] slotBusy,
  output logic              outValid,
  output logic [63:0]       outData,
  output logic              outLast
);

  logic [63:0]       mem [NUM_BLOCKS*BLOCK_WORDS];
  logic [LEN_W-1:0]  blkLen [NUM_BLOCKS];
  logic [ADDR_W-1:0] rdPtr;
  logic [SLOT_W-1:0] headSlot;
  logic              take, takeLast;

  assign headSlot = headSeq[SLOT_W-1:0];
  assign outValid = slotBusy[headSlot];
  assign outData  = mem[{headSlot, rdPtr}];
  assign outLast  = ({1'b0, rdPtr} + LEN_W'(1)) == blkLen[headSlot];
  assign take     = outValid && outReady;
  assign takeLast = take && outLast;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[MEM_W'({wrSlot, wrAddr})] <= wrData;
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotBusy[b] <= 1'b0;
        blkLen[b]   <= '0;
      end else if (strb.commit && (wrSlot == SLOT_W'(b))) begin
        slotBusy[b] <= 1'b1;
        blkLen[b]   <= commitLen;
      end else if (takeLast && (headSlot == SLOT_W'(b))) begin
        slotBusy[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headSeq <= '0;
      rdPtr   <= '0;
    end else if (takeLast) begin
      headSeq <= headSeq + 31'd1;
      rdPtr   <= '0;
    end else if (take) begin
      rdPtr <= rdPtr + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/link_frame_rx.sv
module link_frame_rx
  import lfr_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_WORDS = 512,
  localparam int SLOT_W = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = $clog2(BLOCK_WORDS),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] inWord,
  input  logic [3:0]  inK,
  output logic        ackValid,
  output logic [31:0] ackSeq,
  output logic [15:0] ackId,
  output logic        outValid,
  input  logic        outReady,
  output logic [63:0] outData,
  output logic        outLast
);

  lfr_strobe_t       strb;
  logic [SLOT_W-1:0] wrSlot;
  logic [ADDR_W-1:0] wrAddr;
  logic [63:0]       wrData;
  logic [LEN_W-1:0]  commitLen;
  logic [30:0]       headSeq;
  logic [NUM_BLOCKS-1:0] slotBusy;

  lfr_parser #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS)) uParser (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inK(inK),
    .headSeq(headSeq), .slotBusy(slotBusy), .strb(strb),
    .wrSlot(wrSlot), .wrAddr(wrAddr), .wrData(wrData), .commitLen(commitLen),
    .ackValid(ackValid), .ackSeq(ackSeq), .ackId(ackId)
  );

  lfr_blocks #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS)) uBlocks (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSlot(wrSlot), .wrAddr(wrAddr),
    .wrData(wrData), .commitLen(commitLen), .outReady(outReady),
    .headSeq(headSeq), .slotBusy(slotBusy), .outValid(outValid),
    .outData(outData), .outLast(outLast)
  );

endmodule

// File: rtl/lfr_checker.sv
module lfr_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] inWord,
  input logic [3:0]  inK,
  input logic        ackValid,
  input logic [31:0] ackSeq,
  input logic        outValid,
  input logic        outReady,
  input logic [63:0] outData,
  input logic        outLast
);

  assert_ack_marked_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> ackSeq[31]);

  assert_ack_after_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> ($past(inK) == 4'b0010) && ($past(inWord) == 32'h0000_FD00));

  assert_idle_no_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inK == 4'b1111) |=> !ackValid);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData) && $stable(outLast));

endmodule

bind link_frame_rx lfr_checker uChecker (
  .clk(clk), .rstN(rstN), .inWord(inWord), .inK(inK),
  .ackValid(ackValid), .ackSeq(ackSeq), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outLast(outLast)
);

// File: tb/link_frame_rx_test.sv
module link_frame_rx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inWord = 32'h7CBC_DC1C;
  logic [3:0]  inK = 4'b1111;
  logic        outReady = 1'b1;
  logic        ackValid, outValid, outLast;
  logic [31:0] ackSeq;
  logic [15:0] ackId;
  logic [63:0] outData;

  int tests = 0;
  int fails = 0;
  int cycle = 0;

  logic [31:0] expAckSeq[$];
  logic [15:0] expAckId[$];
  int          expAckCyc[$];
  logic [64:0] expOut[$];

  link_frame_rx uut (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inK(inK),
    .ackValid(ackValid), .ackSeq(ackSeq), .ackId(ackId),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c ^ d;
    for (int i = 0; i < 32; i++) r = r[31] ? ((r << 1) ^ 32'h04C1_1DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [63:0] pay(input int seq, input int k);
    return {16'hA500 ^ 16'(seq), 16'(k), 16'(seq), ~16'(k)};
  endfunction

  function automatic logic [15:0] linkId(input int seq);
    return 16'h1234 ^ 16'(seq);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [3:0] k);
    @(posedge clk); #1;
    inWord = w; inK = k;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(32'h7CBC_DC1C, 4'b1111);
  endtask

  // mode: 0 good, 1 bad CRC, 2 one entry short, 3 bad end word, 4 abandoned
  task automatic sendFrame(input logic [31:0] seq, input int len, input int mode,
                           input bit gaps, input bit expAck);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] hdr;
    int nEnt;
    logic [63:0] e;
    drive(32'h0000_00FB, 4'b0001);
    drive(seq, 4'b0000); c = refCrc(c, seq);
    if (gaps) idle(1);
    hdr = {linkId(int'(seq)), 16'(len)};
    drive(hdr, 4'b0000); c = refCrc(c, hdr);
    nEnt = (mode == 2) ? len - 1 : len;
    for (int p = 0; p < nEnt; p++) begin
      e = pay(int'(seq), p);
      drive(e[63:32], 4'b0000); c = refCrc(c, e[63:32]);
      if (gaps) idle(1);
      drive(e[31:0], 4'b0000); c = refCrc(c, e[31:0]);
      if (mode == 4) return;
    end
    drive((mode == 1) ? (c ^ 32'h1) : c, 4'b0000);
    if (mode == 3) drive(32'h0000_FD01, 4'b0010);
    else drive(32'h0000_FD00, 4'b0010);
    if (expAck) begin
      expAckSeq.push_back(seq | 32'h8000_0000);
      expAckId.push_back(linkId(int'(seq)));
      expAckCyc.push_back(cycle + 1);
    end
    idle(1);
  endtask

  task automatic expectBlock(input int seq, input int len);
    for (int k = 0; k < len; k++) expOut.push_back({k == len - 1, pay(seq, k)});
  endtask

  task automatic drained(input string req);
    idle(40);
    check(expAckSeq.size() == 0, req, "acks outstanding", 64'(expAckSeq.size()), 64'd0);
    check(expOut.size() == 0, req, "data outstanding", 64'(expOut.size()), 64'd0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (ackValid) begin
        if (expAckSeq.size() == 0) begin
          check(1'b0, "R3/R5/R10", "unexpected ack", 64'(ackSeq), 64'd0);
        end else begin
          check(ackSeq == expAckSeq[0], "R4", "ack sequence", 64'(ackSeq), 64'(expAckSeq[0]));
          check(ackId == expAckId[0], "R4", "ack id", 64'(ackId), 64'(expAckId[0]));
          check(cycle == expAckCyc[0], "R4", "ack cycle", 64'(cycle), 64'(expAckCyc[0]));
          void'(expAckSeq.pop_front());
          void'(expAckId.pop_front());
          void'(expAckCyc.pop_front());
        end
      end
      if (outValid && outReady) begin
        if (expOut.size() == 0) begin
          check(1'b0, "R9", "unexpected data", outData, 64'd0);
        end else begin
          check(outData == expOut[0][63:0], "R7", "data", outData, expOut[0][63:0]);
          check(outLast == expOut[0][64], "R7", "last flag", 64'(outLast), 64'(expOut[0][64]));
          void'(expOut.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R11", "outValid after reset", 64'(outValid), 64'd0);
    check(ackValid == 1'b0, "R11", "ackValid after reset", 64'(ackValid), 64'd0);
    rstN = 1'b1;
    idle(3);

    // R2 R11: first good frame is sequence 0
    sendFrame(32'd0, 3, 0, 1'b0, 1'b1); expectBlock(0, 3);
    drained("R2");
    // R1: idle words inside the frame
    sendFrame(32'd1, 2, 0, 1'b1, 1'b1); expectBlock(1, 2);
    drained("R1");
    // R3: bad CRC dropped, then resent
    sendFrame(32'd2, 4, 1, 1'b0, 1'b0);
    drained("R3");
    sendFrame(32'd2, 4, 0, 1'b0, 1'b1); expectBlock(2, 4);
    drained("R3");
    // R5: length mismatch dropped
    sendFrame(32'd3, 3, 2, 1'b0, 1'b0);
    drained("R5");
    sendFrame(32'd3, 1, 0, 1'b0, 1'b1); expectBlock(3, 1);
    drained("R5");
    // R6: abandoned frame followed directly by a new start word
    sendFrame(32'd4, 2, 4, 1'b0, 1'b0);
    sendFrame(32'd4, 2, 0, 1'b0, 1'b1); expectBlock(4, 2);
    drained("R6");
    // R8: out-of-order arrival
    sendFrame(32'd6, 2, 0, 1'b0, 1'b1);
    sendFrame(32'd5, 3, 0, 1'b0, 1'b1);
    expectBlock(5, 3); expectBlock(6, 2);
    drained("R8");
    // R9: copy of a delivered frame
    sendFrame(32'd0, 3, 0, 1'b0, 1'b1);
    drained("R9");
    // R5 R10: bad end word, zero length, bit 31 set
    sendFrame(32'd7, 2, 3, 1'b0, 1'b0);
    sendFrame(32'd7, 0, 0, 1'b0, 1'b0);
    sendFrame(32'h8000_0007, 2, 0, 1'b0, 1'b0);
    drained("R10");
    sendFrame(32'd7, 2, 0, 1'b0, 1'b1); expectBlock(7, 2);
    drained("R5");
    // R7 R9 R10: stalled consumer, held duplicate, full window
    @(posedge clk); #1; outReady = 1'b0;
    sendFrame(32'd8, 2, 0, 1'b0, 1'b1);
    sendFrame(32'd8, 2, 0, 1'b0, 1'b1);
    sendFrame(32'd9, 1, 0, 1'b0, 1'b1);
    sendFrame(32'd10, 3, 0, 1'b0, 1'b1);
    sendFrame(32'd11, 2, 0, 1'b0, 1'b1);
    sendFrame(32'd12, 2, 0, 1'b0, 1'b0);
    drained("R10");
    check(outValid == 1'b1, "R7", "valid while stalled", 64'(outValid), 64'd1);
    check(outData == pay(8, 0), "R7", "head data while stalled", outData, pay(8, 0));
    expectBlock(8, 2); expectBlock(9, 1); expectBlock(10, 3); expectBlock(11, 2);
    @(posedge clk); #1; outReady = 1'b1;
    drained("R9");
    sendFrame(32'd12, 2, 0, 1'b0, 1'b1); expectBlock(12, 2);
    drained("R10");
    check(outValid == 1'b0, "R7", "empty at end", 64'(outValid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule